// File: doc/BRIEF.md
# Triangle-Count Blanking Pulse Generator

This block is a follower timer. It has no counting clock of its own. A one-cycle strobe, sent by a master timer on every overflow of the master, is its only time base. On each strobe the internal count moves one step along a triangle. It rises from zero to a programmable turn-around value, falls back to zero, and starts again. A single registered PWM output is high while the count sits below a programmable threshold.

Because the count moves only on master strobes, the PWM window stays phase-locked to the master. It is also symmetric about the top of the triangle. If the master also toggles a grayscale clock, setting the threshold to the wanted number of grayscale pulses plus one places the low part of the output as a blanking pulse. That number of grayscale rising edges then falls between two consecutive blanking pulses.

Top module: `updown_blank_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the count returns to 0 with the direction set to rising, and `pwm_o` is 0. `pwm_o` stays 0 until the first strobe after reset.
- R2: The count and `pwm_o` change only at a clock edge where `step_i` is 1. In every other cycle both hold their value.
- R3: With a fixed turn-around value T > 0, the k-th strobe after reset gives the count m when m <= T and 2T - m otherwise, where m = k mod 2T. The sequence is 0,1,…,T,T-1,…,1,0,1,…, with no endpoint repeated, and one period lasts 2T strobes.
- R4: The count value reached on a strobe sets `pwm_o` at the same clock edge. `pwm_o` is 1 when that value is strictly less than `cmp_i` and 0 otherwise. The bench sees the new level one edge after it drives the strobe.
- R5: If `cmp_i` is greater than the turn-around value, `pwm_o` is 1 after every strobe.
- R6: If `cmp_i` is 0, `pwm_o` is 0 after every strobe.
- R7: For 1 <= `cmp_i` = N+1 <= T, every 2T-strobe period holds exactly 2N+1 strobes that leave `pwm_o` high.
- R8: A turn-around value of 0 keeps the count at 0 on every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | One-cycle advance strobe from the master timer |
| reload_i | input | CW | Turn-around value at the top of the triangle |
| cmp_i | input | CW | PWM threshold; the output is high while the count is below it |
| pwm_o | output | 1 | Registered PWM / blanking output |

## Verification
The hardest conditions to reach are the two turn-around points. They occur only after many strobes, and at those points an off-by-one in the direction flag would either repeat an endpoint or overshoot it. The only way to see them is through the PWM level at the port. The stimulus sweeps every turn-around value from 0 to 5 against every threshold from 0 to 7. This includes thresholds above the turn-around value and a threshold of zero. Each pairing starts from reset and runs for two full triangles, with idle gaps of varying length between strobes. Each step's expected level is computed from the closed-form triangle position of the strobe index, so every reversal and every threshold crossing is pinned to a single strobe.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  typedef enum logic {
    DIR_RISE = 1'b0,
    DIR_FALL = 1'b1
  } ubt_dir_e;
endpackage

// File: rtl/ubt_updown_counter.sv
module ubt_updown_counter
  import ubt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic [CW-1:0] reload_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_next_o
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ZERO = '0;

  logic [CW-1:0] cnt_q, cnt_d;
  ubt_dir_e      dir_q, dir_d;

  // next position on the triangle, used only when a strobe arrives
  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (dir_q == DIR_RISE) begin
      if (cnt_q < reload_i) begin
        cnt_d = cnt_q + ONE;
        dir_d = ((cnt_q + ONE) >= reload_i) ? DIR_FALL : DIR_RISE;
      end else begin
        cnt_d = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
        dir_d = (cnt_q > ONE) ? DIR_FALL : DIR_RISE;
      end
    end else begin
      if (cnt_q > ZERO) begin
        cnt_d = cnt_q - ONE;
        dir_d = (cnt_q == ONE) ? DIR_RISE : DIR_FALL;
      end else begin
        cnt_d = (reload_i > ZERO) ? ONE : ZERO;
        dir_d = (reload_i > ONE) ? DIR_RISE : DIR_FALL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ZERO;
      dir_q <= DIR_RISE;
    end else if (step_i) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(cnt_q));

  // R3
  rise_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && dir_q == DIR_RISE && cnt_q < reload_i) |=> cnt_q == $past(cnt_q) + ONE);

  // R3
  fall_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && dir_q == DIR_FALL && cnt_q > ZERO) |=> cnt_q == $past(cnt_q) - ONE);

  // R8
  flat_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && reload_i == ZERO && cnt_q == ZERO) |=> cnt_q == ZERO);
endmodule

// File: rtl/ubt_blank_compare.sv
module ubt_blank_compare #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic [CW-1:0] cnt_next_i,
  input  logic [CW-1:0] cmp_i,
  output logic          pwm_o
);
  logic pwm_q;

  always_ff @(posedge clk) begin
    if (rst)         pwm_q <= 1'b0;
    else if (step_i) pwm_q <= (cnt_next_i < cmp_i);
  end

  assign pwm_o = pwm_q;

  // R2
  pwm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(pwm_q));

  // R6
  zero_cmp_low_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && cmp_i == '0) |=> !pwm_q);
endmodule

// File: rtl/updown_blank_timer.sv
module updown_blank_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic [CW-1:0] reload_i,
  input  logic [CW-1:0] cmp_i,
  output logic          pwm_o
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_next;

  ubt_updown_counter #(.CW(CW)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step_i),
    .reload_i   (reload_i),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next)
  );

  ubt_blank_compare #(.CW(CW)) u_compare (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step_i),
    .cnt_next_i (cnt_next),
    .cmp_i      (cmp_i),
    .pwm_o      (pwm_o)
  );

  // R5
  high_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && cmp_i > reload_i && cnt <= reload_i) |=> pwm_o);

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> !pwm_o);
endmodule

// File: tb/updown_blank_timer_bench.sv
module updown_blank_timer_bench;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step = 1'b0;
  logic [CW-1:0] reload = '0;
  logic [CW-1:0] cmp = '0;
  logic          pwm;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  updown_blank_timer #(.CW(CW)) u_updown_blank_timer (
    .clk      (clk),
    .rst      (rst),
    .step_i   (step),
    .reload_i (reload),
    .cmp_i    (cmp),
    .pwm_o    (pwm)
  );

  function automatic int tri_pos(int k, int t);
    int m;
    if (t == 0) return 0;
    m = k % (2 * t);
    return (m <= t) ? m : 2 * t - m;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pwm actual=%0b expected=%0b (reload=%0d cmp=%0d)",
               req, act, exp, reload, cmp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (reload=%0d cmp=%0d)",
               req, act, exp, reload, cmp);
    end
  endtask

  task automatic run_cfg(int t, int c);
    int    steps;
    int    highs;
    string tag;
    logic  exp;
    @(negedge clk);
    reload = CW'(t);
    cmp    = CW'(c);
    rst    = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1", pwm, 1'b0);
    @(negedge clk);
    check("R1", pwm, 1'b0);
    if (t == 0)      tag = "R8";
    else if (c == 0) tag = "R6";
    else if (c > t)  tag = "R5";
    else             tag = "R3_R4";
    steps = (t == 0) ? 4 : 4 * t + 1;
    highs = 0;
    for (int k = 1; k <= steps; k++) begin
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      exp = (tri_pos(k, t) < c);
      check(tag, pwm, exp);
      if (t > 0 && k > 2 * t && k <= 4 * t && pwm) highs++;
      for (int g = 0; g < (k % 3); g++) begin
        @(negedge clk);
        check("R2", pwm, exp);
      end
    end
    if (t > 0 && c >= 1 && c <= t)
      check_int("R7", highs, 2 * (c - 1) + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t <= 5; t++)
      for (int c = 0; c <= 7; c++)
        run_cfg(t, c);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule